// File: doc/BRIEF.md
# Interleaved Sample-Set Bank Address Generator

This block turns the integer corner of a resampling cell in a 512-per-axis volume into eight memory addresses, one for each of eight interleaved sample banks. A sample's bank is chosen by the low bit of each of its three coordinates, so the eight corners of any 2×2×2 cell fall in eight different banks. The eight corners can then be read in one parallel access with no bank conflict. Three further set kinds move the odd-bank samples along one axis, so that neighbour samples for gradient estimation can also be read in one access each.

For every bank the block works out the sample's in-bank location (U, V, W) with a per-axis rule. It then packs that location into either a column (page-mode) address or a row (page-open) address, and reports which of the eight memory units inside the bank holds the sample. A location that falls outside the volume is flagged instead of wrapping. Results are registered and appear one cycle after a valid request. When no request is presented they hold their last value.

Top module: `sset_addr_gen`

## Requirements
- R1: For set kind 0 (corner set), bank k uses, on each axis a (bit 0 of k for x/U, bit 1 for y/V, bit 2 for z/W), location ⌊c/2⌋ + c[0] when bit a of k is 0, and ⌊c/2⌋ when it is 1. Here c is the reference coordinate on that axis.
- R2: Set kinds 1, 2 and 3 extend the x, y and z axis respectively. On the extended axis, banks with that bank bit set use ⌊c/2⌋ − 1 when c is odd and ⌊c/2⌋ + 1 when c is even. All other axes and banks follow the R1 rule.
- R3: Each bank's unit select is the 3-bit value {W[0], V[0], U[0]}.
- R4: With row_mode low, the bank address is W[3:1]·128 + V[4:1]·8 + U[3:1], which is 10 bits zero-extended to the address width.
- R5: With row_mode high, the bank address is W[7:4]·128 + V[7:5]·16 + U[7:4].
- R6: A bank whose location on any axis is below 0 or above 255 raises its bit of bank_oor, and drives address 0 and unit select 0.
- R7: Results for a request with in_valid high appear after the next rising clock edge, with out_valid high for exactly that cycle.
- R8: While in_valid is low, bank_addr, bank_unit and bank_oor keep their values.
- R9: During reset, out_valid, every address, every unit select and every out-of-range flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; loads the output registers |
| ref_x | input | 9 | Cell corner, x coordinate |
| ref_y | input | 9 | Cell corner, y coordinate |
| ref_z | input | 9 | Cell corner, z coordinate |
| set_kind | input | 2 | 0 corner set, 1 x-extended, 2 y-extended, 3 z-extended |
| row_mode | input | 1 | 1 row address, 0 column address |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| bank_addr | output | 88 | Eight 11-bit addresses; bank k at bits [11k+10:11k] |
| bank_unit | output | 24 | Eight 3-bit unit selects; bank k at bits [3k+2:3k] |
| bank_oor | output | 8 | Per-bank out-of-range flag; bank k at bit k |

## Verification
The vectors cover every set kind, each with both even and odd reference coordinates. Even and odd references separate the "+c[0]" rule from the "±1" rule, because the two rules agree at some parities and not at others. Corners at 0, 1, 510 and 511 drive locations to −1 and 256 on the axis each set kind touches. These show whether the out-of-range test is applied per bank and only on the correct axis. Row and column packing are both tried with coordinates whose high and low bits differ, so a swapped or shifted field shows up in the address. Idle cycles with changed inputs separate the hold behaviour from the load behaviour.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int AXES      = 3;
  localparam int NUM_BANKS = 2 ** AXES;
  localparam int UNIT_W    = AXES;
  localparam int COL_W     = 10;
  localparam int ROW_W     = 11;

  typedef enum logic [1:0] {
    SET_CORNER = 2'd0,
    SET_XEXT   = 2'd1,
    SET_YEXT   = 2'd2,
    SET_ZEXT   = 2'd3
  } set_kind_e;
endpackage

// File: rtl/sag_axis_loc.sv
// One axis of one bank: in-bank location and range check.
module sag_axis_loc #(
  parameter int COORD_W = 9
) (
  input  logic [COORD_W-1:0] coord,
  input  logic               bank_bit,
  input  logic               extend,
  output logic [COORD_W-2:0] loc,
  output logic               oor
);
  localparam int SUM_W = COORD_W + 1;
  localparam logic [SUM_W-1:0] ONE = SUM_W'(1);

  logic [SUM_W-1:0] half_ext;
  logic [SUM_W-1:0] sum;

  assign half_ext = {2'b00, coord[COORD_W-1:1]};

  always_comb begin
    if (!bank_bit) begin
      sum = half_ext + {{(SUM_W-1){1'b0}}, coord[0]};
    end else if (extend) begin
      sum = coord[0] ? (half_ext - ONE) : (half_ext + ONE);
    end else begin
      sum = half_ext;
    end
    // top bit: went negative; next bit: reached the location count
    oor = sum[SUM_W-1] | sum[SUM_W-2];
    loc = sum[SUM_W-3:0];
  end
endmodule

// File: rtl/sag_bank.sv
// Address and unit select for one bank, fixed by the BANK index.
module sag_bank
  import sag_pkg::*;
#(
  parameter int COORD_W = 9,
  parameter int ADDR_W  = ROW_W,
  parameter int BANK    = 0
) (
  input  logic [COORD_W-1:0] ref_x,
  input  logic [COORD_W-1:0] ref_y,
  input  logic [COORD_W-1:0] ref_z,
  input  logic [1:0]         set_kind,
  input  logic               row_mode,
  output logic [ADDR_W-1:0]  addr,
  output logic [UNIT_W-1:0]  unit,
  output logic               oor
);
  localparam int LOC_W = COORD_W - 1;
  localparam logic [AXES-1:0] BANK_SEL = AXES'(BANK);

  logic [COORD_W-1:0] crd    [AXES];
  logic [LOC_W-1:0]   loc    [AXES];
  logic [AXES-1:0]    oor_ax;

  assign crd[0] = ref_x;
  assign crd[1] = ref_y;
  assign crd[2] = ref_z;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    sag_axis_loc #(.COORD_W(COORD_W)) u_axis (
      .coord    (crd[a]),
      .bank_bit (BANK_SEL[a]),
      .extend   (set_kind == 2'(a + 1)),
      .loc      (loc[a]),
      .oor      (oor_ax[a])
    );
  end

  logic [LOC_W-1:0] u_loc, v_loc, w_loc;
  logic [COL_W-1:0] col_a;
  logic [ROW_W-1:0] row_a;

  assign u_loc = loc[0];
  assign v_loc = loc[1];
  assign w_loc = loc[2];

  // column: W[3:1] at 9:7, V[4:1] at 6:3, U[3:1] at 2:0
  assign col_a = {w_loc[3:1], v_loc[4:1], u_loc[3:1]};
  // row: W[7:4] at 10:7, V[7:5] at 6:4, U[7:4] at 3:0
  assign row_a = {w_loc[7:4], v_loc[7:5], u_loc[7:4]};

  always_comb begin
    oor = |oor_ax;
    if (oor) begin
      addr = '0;
      unit = '0;
    end else begin
      addr = row_mode ? ADDR_W'(row_a) : ADDR_W'(col_a);
      unit = {w_loc[0], v_loc[0], u_loc[0]};
    end
  end
endmodule

// File: rtl/sset_addr_gen.sv
module sset_addr_gen
  import sag_pkg::*;
#(
  parameter int COORD_W = 9,
  parameter int ADDR_W  = ROW_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [COORD_W-1:0]            ref_x,
  input  logic [COORD_W-1:0]            ref_y,
  input  logic [COORD_W-1:0]            ref_z,
  input  logic [1:0]                    set_kind,
  input  logic                          row_mode,
  output logic                          out_valid,
  output logic [NUM_BANKS*ADDR_W-1:0]   bank_addr,
  output logic [NUM_BANKS*UNIT_W-1:0]   bank_unit,
  output logic [NUM_BANKS-1:0]          bank_oor
);
  localparam int ADDR_BUS_W = NUM_BANKS * ADDR_W;
  localparam int UNIT_BUS_W = NUM_BANKS * UNIT_W;

  logic [ADDR_BUS_W-1:0] cmb_addr, nxt_addr, q_addr;
  logic [UNIT_BUS_W-1:0] cmb_unit, nxt_unit, q_unit;
  logic [NUM_BANKS-1:0]  cmb_oor,  nxt_oor,  q_oor;
  logic                  nxt_valid, q_valid;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sag_bank #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .BANK(b)) u_bank (
      .ref_x    (ref_x),
      .ref_y    (ref_y),
      .ref_z    (ref_z),
      .set_kind (set_kind),
      .row_mode (row_mode),
      .addr     (cmb_addr[b*ADDR_W +: ADDR_W]),
      .unit     (cmb_unit[b*UNIT_W +: UNIT_W]),
      .oor      (cmb_oor[b])
    );
  end

  always_comb begin
    nxt_valid = in_valid;
    if (in_valid) begin
      nxt_addr = cmb_addr;
      nxt_unit = cmb_unit;
      nxt_oor  = cmb_oor;
    end else begin
      nxt_addr = q_addr;
      nxt_unit = q_unit;
      nxt_oor  = q_oor;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_addr  <= '0;
      q_unit  <= '0;
      q_oor   <= '0;
    end else begin
      q_valid <= nxt_valid;
      q_addr  <= nxt_addr;
      q_unit  <= nxt_unit;
      q_oor   <= nxt_oor;
    end
  end

  assign out_valid = q_valid;
  assign bank_addr = q_addr;
  assign bank_unit = q_unit;
  assign bank_oor  = q_oor;
endmodule

// File: rtl/sset_addr_gen_chk.sv
module sset_addr_gen_chk
  import sag_pkg::*;
#(
  parameter int COORD_W = 9,
  parameter int ADDR_W  = ROW_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic [COORD_W-1:0]          ref_x,
  input logic [COORD_W-1:0]          ref_y,
  input logic [COORD_W-1:0]          ref_z,
  input logic [1:0]                  set_kind,
  input logic                        row_mode,
  input logic                        out_valid,
  input logic [NUM_BANKS*ADDR_W-1:0] bank_addr,
  input logic [NUM_BANKS*UNIT_W-1:0] bank_unit,
  input logic [NUM_BANKS-1:0]        bank_oor
);
  localparam logic [COORD_W-1:0] CMAX = '1;

  a_r7_load_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(bank_addr) && $stable(bank_unit) && $stable(bank_oor)));

  a_r1_corner_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && set_kind == 2'd0 && ref_x != CMAX && ref_y != CMAX && ref_z != CMAX)
      |=> (bank_oor == '0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    a_r6_oor_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
      bank_oor[b] |-> (bank_addr[b*ADDR_W +: ADDR_W] == '0 &&
                       bank_unit[b*UNIT_W +: UNIT_W] == '0));

    a_r4_col_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !row_mode) |=> ((bank_addr[b*ADDR_W +: ADDR_W] >> COL_W) == '0));
  end
endmodule

bind sset_addr_gen sset_addr_gen_chk #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .ref_x     (ref_x),
  .ref_y     (ref_y),
  .ref_z     (ref_z),
  .set_kind  (set_kind),
  .row_mode  (row_mode),
  .out_valid (out_valid),
  .bank_addr (bank_addr),
  .bank_unit (bank_unit),
  .bank_oor  (bank_oor)
);

// File: tb/sset_addr_gen_bench.sv
`timescale 1ns/1ps
module sset_addr_gen_bench;
  localparam int NB = 8;
  localparam int AW = 11;
  localparam int UW = 3;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [8:0]    ref_x = '0, ref_y = '0, ref_z = '0;
  logic [1:0]    set_kind = '0;
  logic          row_mode = 1'b0;
  logic          out_valid;
  logic [NB*AW-1:0] bank_addr;
  logic [NB*UW-1:0] bank_unit;
  logic [NB-1:0]    bank_oor;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sset_addr_gen u_sset_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .ref_x(ref_x), .ref_y(ref_y), .ref_z(ref_z),
    .set_kind(set_kind), .row_mode(row_mode),
    .out_valid(out_valid), .bank_addr(bank_addr),
    .bank_unit(bank_unit), .bank_oor(bank_oor)
  );

  // {x, y, z, set kind, row mode}
  localparam logic [29:0] VEC [NV] = '{
    {9'd0,   9'd0,   9'd0,   2'd0, 1'b0},
    {9'd37,  9'd100, 9'd255, 2'd0, 1'b0},
    {9'd511, 9'd511, 9'd511, 2'd0, 1'b0},
    {9'd200, 9'd301, 9'd45,  2'd1, 1'b0},
    {9'd1,   9'd8,   9'd9,   2'd1, 1'b0},
    {9'd510, 9'd3,   9'd3,   2'd1, 1'b0},
    {9'd14,  9'd1,   9'd77,  2'd2, 1'b0},
    {9'd60,  9'd510, 9'd123, 2'd3, 1'b1},
    {9'd300, 9'd400, 9'd500, 2'd0, 1'b1},
    {9'd129, 9'd257, 9'd385, 2'd2, 1'b1},
    {9'd77,  9'd66,  9'd1,   2'd3, 1'b1},
    {9'd255, 9'd256, 9'd257, 2'd3, 1'b0}
  };

  function automatic int mloc(int c, int bb, int ext);
    int h = c / 2;
    if (bb == 0) return h + (c % 2);
    if (ext != 0) return (c % 2 == 1) ? h - 1 : h + 1;
    return h;
  endfunction

  task automatic model(input int x, input int y, input int z, input int k,
                       input int row, input int b,
                       output int ea, output int eu, output int eo);
    int u = mloc(x, b & 1,        (k == 1) ? 1 : 0);
    int v = mloc(y, (b >> 1) & 1, (k == 2) ? 1 : 0);
    int w = mloc(z, (b >> 2) & 1, (k == 3) ? 1 : 0);
    eo = (u < 0 || u > 255 || v < 0 || v > 255 || w < 0 || w > 255) ? 1 : 0;
    if (eo != 0) begin
      ea = 0; eu = 0;
    end else begin
      if (row != 0) ea = ((w >> 4) & 15) * 128 + ((v >> 5) & 7) * 16 + ((u >> 4) & 15);
      else          ea = ((w >> 1) & 7) * 128 + ((v >> 1) & 15) * 8 + ((u >> 1) & 7);
      eu = (w % 2) * 4 + (v % 2) * 2 + (u % 2);
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input int x, input int y, input int z, input int k, input int row);
    for (int b = 0; b < NB; b++) begin
      int ea, eu, eo;
      string rs;
      model(x, y, z, k, row, b, ea, eu, eo);
      rs = (k == 0) ? "R1" : "R2";
      check({rs, (row != 0) ? "/R5" : "/R4"}, $sformatf("bank %0d addr", b),
            int'(bank_addr[b*AW +: AW]), ea);
      check({rs, "/R3"}, $sformatf("bank %0d unit", b), int'(bank_unit[b*UW +: UW]), eu);
      check({rs, "/R6"}, $sformatf("bank %0d oor", b), int'(bank_oor[b]), eo);
    end
  endtask

  task automatic request(input int x, input int y, input int z, input int k, input int row);
    @(negedge clk);
    ref_x = 9'(x); ref_y = 9'(y); ref_z = 9'(z);
    set_kind = 2'(k); row_mode = row[0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [NB*AW-1:0] held_a;
    logic [NB*UW-1:0] held_u;
    logic [NB-1:0]    held_o;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "out_valid in reset", int'(out_valid), 0);
    check("R9", "addr in reset", int'(bank_addr != '0), 0);
    check("R9", "unit/oor in reset", int'(bank_unit != '0 || bank_oor != '0), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      request(int'(v[29:21]), int'(v[20:12]), int'(v[11:3]), int'(v[2:1]), int'(v[0]));
      check("R7", "out_valid one cycle after request", int'(out_valid), 1);
      check_all(int'(v[29:21]), int'(v[20:12]), int'(v[11:3]), int'(v[2:1]), int'(v[0]));
    end

    // R7: valid drops on the idle cycle after a request
    @(negedge clk);
    check("R7", "out_valid after idle cycle", int'(out_valid), 0);

    // R8: changed inputs with in_valid low leave results untouched
    held_a = bank_addr; held_u = bank_unit; held_o = bank_oor;
    ref_x = 9'd3; ref_y = 9'd5; ref_z = 9'd7; set_kind = 2'd1; row_mode = 1'b1;
    repeat (2) @(negedge clk);
    check("R8", "addr held while idle", int'(bank_addr == held_a), 1);
    check("R8", "unit/oor held while idle", int'(bank_unit == held_u && bank_oor == held_o), 1);

    // R6: every bank but 7 out of range for the top corner
    request(511, 511, 511, 0, 1);
    check("R6", "oor pattern at top corner", int'(bank_oor), 8'h7F);
    check_all(511, 511, 511, 0, 1);

    // R9: asynchronous reset clears loaded results
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9", "addr cleared by reset", int'(bank_addr != '0), 0);
    check("R9", "oor cleared by reset", int'(bank_oor), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule